// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block serializes words for a synchronous serial port. Software writes a word into a holding register. The word waits there until a start event arrives on a tick of the selected transmit clock. On that tick the word moves into the shifter, and the frame begins. A frame opens with an optional field of synchronization bits, taken from a configured pattern. The data word follows, shifted out at one bit per transmit-clock tick.

The transmit clock comes from one of two enable inputs. Each is a single-cycle pulse synchronous to the system clock, so every register in the block runs on the system clock. A frame-sync output marks the start of each frame. Two status outputs report on the holding register and the shifter: one says a new word may be written, and the other says nothing at all is pending.

Top module: `sync_frame_tx`

## Requirements
- R1: During and right after reset, txrdy=1, txempty=1, txd=0 and frame_sync=0.
- R2: A frame starts only on a selected-clock tick on which start_evt=1 and the holding register holds a word, and the shifter is idle or in the bit time after its last bit. A start event with no word pending sends nothing. A word with no start event sends nothing.
- R3: txd and frame_sync change only on ticks of the selected transmit clock. clk_sel=0 selects tclk_a_en and clk_sel=1 selects tclk_b_en. The unselected enable has no effect.
- R4: When the sync length L is from 1 to 16, each frame begins with L bits of cfg_sync_pat, sent from bit L-1 down to bit 0. Length codes above 16 act as 16. A length of 0 sends no sync bits.
- R5: After the sync bits come N data bits, where N is cfg_data_len from 1 to 32. A code of 0 acts as 1, and codes above 32 act as 32. With cfg_msb_first=1 the bits go from bit N-1 down to bit 0. With cfg_msb_first=0 they go from bit 0 up to bit N-1.
- R6: frame_sync is 1 for every sync bit time. When the sync length is 0, it is 1 for the first data bit time only. It is 0 at all other times.
- R7: txrdy is 1 exactly when the holding register is empty. A write makes it 0 from the next cycle. The start of a frame empties the holding register, which sets txrdy.
- R8: txempty is 1 only when the holding register is empty and the shifter is idle. The shifter counts as busy until one tick after its last bit.
- R9: When a frame ends and no new frame starts, txd keeps its last level until the next frame.
- R10: A write in the same cycle as a frame start does not change that frame. The new word stays in the holding register for a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Word to write |
| start_evt | input | 1 | Start event, sampled on selected-clock ticks |
| clk_sel | input | 1 | Transmit clock choice: 0 selects A, 1 selects B |
| tclk_a_en | input | 1 | Transmit clock tick, source A |
| tclk_b_en | input | 1 | Transmit clock tick, source B |
| cfg_data_len | input | $clog2(DW+1) | Data bits per frame |
| cfg_sync_len | input | $clog2(SW+1) | Sync bits per frame |
| cfg_sync_pat | input | SW | Sync bit pattern |
| cfg_msb_first | input | 1 | 1 sends the highest data bit first |
| txd | output | 1 | Serial data |
| frame_sync | output | 1 | Frame marker |
| txrdy | output | 1 | Holding register may be written |
| txempty | output | 1 | Holding register and shifter both idle |

## Verification
The bench builds the block with DW=32 and SW=16. This makes full-width 32-bit words and 16-bit sync fields reachable. The 6-bit and 5-bit length fields can also carry codes above those widths, which exercises the clamping for both data length and sync length, as well as the zero-length cases. The stimulus randomizes both tick sources, the clock choice, start events and writes across phases that differ in density. This produces back-to-back frames, frames that end with nothing pending, and writes that land on the launch cycle.

// File: rtl/sync_frame_tx.sv
module sync_frame_tx #(
  parameter int DW = 32,
  parameter int SW = 16,
  localparam int DLW = $clog2(DW + 1),
  localparam int SLW = $clog2(SW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           start_evt,
  input  logic           clk_sel,
  input  logic           tclk_a_en,
  input  logic           tclk_b_en,
  input  logic [DLW-1:0] cfg_data_len,
  input  logic [SLW-1:0] cfg_sync_len,
  input  logic [SW-1:0]  cfg_sync_pat,
  input  logic           cfg_msb_first,
  output logic           txd,
  output logic           frame_sync,
  output logic           txrdy,
  output logic           txempty
);

  logic [DW-1:0]  hold_q, sh;
  logic [SW-1:0]  ssh;
  logic           hold_v, busy, msb_q, txd_q, fs_q;
  logic [SLW-1:0] scnt;
  logic [DLW-1:0] dcnt;

  wire bit_en = clk_sel ? tclk_b_en : tclk_a_en;
  wire last   = busy && scnt == '0 && dcnt == '0;
  wire launch = bit_en && start_evt && hold_v && (!busy || last);

  wire [DLW-1:0] dlen = (cfg_data_len == '0) ? DLW'(1) :
                        (cfg_data_len > DLW'(DW)) ? DLW'(DW) : cfg_data_len;
  wire [SLW-1:0] slen = (cfg_sync_len > SLW'(SW)) ? SLW'(SW) : cfg_sync_len;

  wire [DW-1:0] data_al = cfg_msb_first ? (hold_q << (DLW'(DW) - dlen)) : hold_q;
  wire [SW-1:0] sync_al = cfg_sync_pat << (SLW'(SW) - slen);
  wire          first_bit = cfg_msb_first ? data_al[DW-1] : data_al[0];
  wire [DW-1:0] data_adv  = cfg_msb_first ? (data_al << 1) : (data_al >> 1);
  wire          next_bit  = msb_q ? sh[DW-1] : sh[0];
  wire [DW-1:0] sh_adv    = msb_q ? (sh << 1) : (sh >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      busy   <= 1'b0;
      sh     <= '0;
      ssh    <= '0;
      scnt   <= '0;
      dcnt   <= '0;
      msb_q  <= 1'b0;
      txd_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      if (launch) hold_v <= 1'b0;
      if (wr_en) begin
        hold_q <= wr_data;
        hold_v <= 1'b1;
      end
      if (bit_en) begin
        if (launch) begin
          busy  <= 1'b1;
          msb_q <= cfg_msb_first;
          fs_q  <= 1'b1;
          if (slen != '0) begin
            txd_q <= sync_al[SW-1];
            ssh   <= sync_al << 1;
            scnt  <= slen - SLW'(1);
            sh    <= data_al;
            dcnt  <= dlen;
          end else begin
            txd_q <= first_bit;
            sh    <= data_adv;
            scnt  <= '0;
            dcnt  <= dlen - DLW'(1);
          end
        end else if (busy) begin
          if (scnt != '0) begin
            txd_q <= ssh[SW-1];
            ssh   <= ssh << 1;
            scnt  <= scnt - SLW'(1);
            fs_q  <= 1'b1;
          end else if (dcnt != '0) begin
            txd_q <= next_bit;
            sh    <= sh_adv;
            dcnt  <= dcnt - DLW'(1);
            fs_q  <= 1'b0;
          end else begin
            busy <= 1'b0;
            fs_q <= 1'b0;
          end
        end else begin
          fs_q <= 1'b0;
        end
      end
    end
  end

  assign txd        = txd_q;
  assign frame_sync = fs_q;
  assign txrdy      = !hold_v;
  assign txempty    = !hold_v && !busy;

  assert_launch_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt && bit_en));

  assert_quiet_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(txd) && $stable(frame_sync)));

  assert_marker_at_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> frame_sync);

  assert_write_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !txrdy);

  assert_empty_implies_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txempty |-> txrdy);

  assert_idle_line_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(txd));

endmodule

// File: tb/sync_frame_tx_tb_top.sv
module sync_frame_tx_tb_top;
  localparam int DW = 32;
  localparam int SW = 16;
  localparam int DLW = $clog2(DW + 1);
  localparam int SLW = $clog2(SW + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           start_evt = 1'b0;
  logic           clk_sel = 1'b0;
  logic           tclk_a_en = 1'b0;
  logic           tclk_b_en = 1'b0;
  logic [DLW-1:0] cfg_data_len = DLW'(8);
  logic [SLW-1:0] cfg_sync_len = '0;
  logic [SW-1:0]  cfg_sync_pat = '0;
  logic           cfg_msb_first = 1'b1;
  logic           txd, frame_sync, txrdy, txempty;

  sync_frame_tx #(.DW(DW), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .start_evt(start_evt), .clk_sel(clk_sel), .tclk_a_en(tclk_a_en),
    .tclk_b_en(tclk_b_en), .cfg_data_len(cfg_data_len),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_pat(cfg_sync_pat),
    .cfg_msb_first(cfg_msb_first), .txd(txd), .frame_sync(frame_sync),
    .txrdy(txrdy), .txempty(txempty));

  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: a queue of pending line bits per frame
  bit          m_q[$];
  bit          m_fq[$];
  logic [DW-1:0] m_hold;
  bit          m_hv, m_busy, m_txd, m_fs;

  always @(posedge clk) begin
    bit tick, go;
    int dl, sl;
    if (!rst_n) begin
      m_hv = 0; m_busy = 0; m_txd = 0; m_fs = 0; m_hold = '0;
      m_q.delete(); m_fq.delete();
    end else begin
      tick = clk_sel ? tclk_b_en : tclk_a_en;
      go = tick && start_evt && m_hv && (!m_busy || m_q.size() == 0);
      if (tick) begin
        if (go) begin
          dl = (cfg_data_len == 0) ? 1 : ((int'(cfg_data_len) > DW) ? DW : int'(cfg_data_len));
          sl = (int'(cfg_sync_len) > SW) ? SW : int'(cfg_sync_len);
          m_q.delete(); m_fq.delete();
          for (int i = sl - 1; i >= 0; i--) begin
            m_q.push_back(cfg_sync_pat[i]);
            m_fq.push_back(1'b1);
          end
          for (int k = 0; k < dl; k++) begin
            m_q.push_back(cfg_msb_first ? m_hold[dl-1-k] : m_hold[k]);
            m_fq.push_back(k == 0 && sl == 0);
          end
          m_txd = m_q.pop_front();
          m_fs = m_fq.pop_front();
          m_busy = 1;
        end else if (m_busy) begin
          if (m_q.size() > 0) begin
            m_txd = m_q.pop_front();
            m_fs = m_fq.pop_front();
          end else begin
            m_busy = 0;
            m_fs = 0;
          end
        end else begin
          m_fs = 0;
        end
      end
      if (go) m_hv = 0;
      if (wr_en) begin
        m_hold = wr_data;
        m_hv = 1;
      end
    end
  end

  task automatic compare();
    chk(txd == m_txd, "R2 R3 R4 R5 R9 R10 txd", int'(txd), int'(m_txd));
    chk(frame_sync == m_fs, "R3 R6 frame_sync", int'(frame_sync), int'(m_fs));
    chk(txrdy == !m_hv, "R7 R10 txrdy", int'(txrdy), int'(!m_hv));
    chk(txempty == (!m_hv && !m_busy), "R8 txempty", int'(txempty), int'(!m_hv && !m_busy));
  endtask

  task automatic pick_cfg(int fdl, int fsl);
    cfg_data_len  = (fdl >= 0) ? DLW'(fdl) : DLW'($urandom % 40);
    cfg_sync_len  = (fsl >= 0) ? SLW'(fsl) : SLW'($urandom % 20);
    cfg_sync_pat  = SW'($urandom);
    cfg_msb_first = 1'($urandom);
  endtask

  task automatic run_phase(int n, int pa, int pb, int sel, int ps, int pw, int fdl, int fsl);
    pick_cfg(fdl, fsl);
    repeat (n) begin
      @(negedge clk);
      compare();
      tclk_a_en = ($urandom % pa) == 0;
      tclk_b_en = ($urandom % pb) == 0;
      clk_sel   = (sel >= 0) ? 1'(sel) : 1'($urandom);
      start_evt = ($urandom % ps) == 0;
      wr_en     = ($urandom % pw) == 0;
      wr_data   = $urandom;
      if (($urandom % 60) == 0) pick_cfg(fdl, fsl);
    end
  endtask

  initial begin
    #(300000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txrdy == 1'b1, "R1 txrdy in reset", int'(txrdy), 1);
    chk(txempty == 1'b1, "R1 txempty in reset", int'(txempty), 1);
    chk(txd == 1'b0, "R1 txd in reset", int'(txd), 0);
    chk(frame_sync == 1'b0, "R1 frame_sync in reset", int'(frame_sync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txrdy && txempty && !txd && !frame_sync, "R1 after reset", int'({txrdy, txempty, txd, frame_sync}), 12);
    // start events with no word: nothing goes out (R2)
    run_phase(200, 1, 1, 0, 2, 1000000, 8, 0);
    // dense source A, no sync, one-bit words
    run_phase(2000, 1, 2, 0, 3, 4, 1, 0);
    // sparse source B, full sync and full word, source A toggling as noise
    run_phase(3000, 2, 3, 1, 4, 6, 32, 16);
    // sync length 0 with varied word lengths, rare writes so the line idles (R9)
    run_phase(3000, 1, 2, 0, 5, 40, -1, 0);
    // writes landing on launch ticks (R10)
    run_phase(2000, 1, 1, 1, 1, 2, -1, -1);
    // everything random, including clamped length codes
    run_phase(6000, 2, 2, -1, 3, 8, -1, -1);
    @(negedge clk);
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule